// File: doc/BRIEF.md
# Pin waveform format combiner

This block sits between the pattern sequencer and the pin-electronics switches of a digital tester. For every pin it takes two pattern bits each period, one for the drive level and one for the drive enable. Each bit comes with its own timing-generator pulse. A per-pin format select for each path picks how the bit and the pulse are combined: a held level that changes only on the timing edge, an AND pulse that returns to 0, an OR pulse that returns to 1, or an XOR that brackets the bit with its complement. It can also pick a static level that ignores the pattern. From the chosen enable it derives the active-load switch, which either takes the opposite state of the driver or is forced on or off.

All three outputs of a pin are registered, so each one changes exactly one clock after the inputs that decide it are sampled. The inputs are plain per-period control and timing levels. They carry no handshake: the sequencer presents a value every clock and the block consumes it every clock, so there is no back-pressure.

Top module: `pwf_format_combiner`

## Requirements
- R1: With format code 0 (held level), the path output takes the pattern bit that was sampled when its timing input was first seen high after a low sample. It shows that value one clock later and keeps it until the next such rising edge.
- R2: With format code 1 (return to zero), the path output one clock after a sample equals pattern AND timing.
- R3: With format code 2 (return to one), the path output one clock after a sample equals pattern OR NOT timing.
- R4: With format code 3 (complement surround), the path output one clock after a sample equals pattern XOR timing.
- R5: Format code 4 gives a constant 1 and code 5 gives a constant 0. Codes 6 and 7 give a constant 0. The pattern bit and the timing input have no effect under any of these codes.
- R6: The drive-enable path uses the same codes with its own select, pattern bit and timing input, independently of the drive-data path.
- R7: Load mode 0 makes the load output the inverse of the drive-enable output in every cycle. Mode 1 holds the load on (1). Modes 2 and 3 hold it off (0).
- R8: A high synchronous clear sets the held-level state of both paths of every pin to 0. It takes precedence over a rising timing edge in the same cycle. Formats other than code 0 are unaffected by it.
- R9: During and after reset all outputs are 0, the held-level state is 0, and the last timing sample counts as low. A high timing input at the first sample after reset is therefore a rising edge.
- R10: Each pin is combined only from its own selects, pattern bits and timing inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the held-level state |
| dat_pat | input | NUM_PINS | Drive-data pattern bit per pin |
| dat_tg | input | NUM_PINS | Drive-data timing pulse per pin |
| dat_sel | input | NUM_PINS x 3 | Drive-data format code per pin |
| ena_pat | input | NUM_PINS | Drive-enable pattern bit per pin |
| ena_tg | input | NUM_PINS | Drive-enable timing pulse per pin |
| ena_sel | input | NUM_PINS x 3 | Drive-enable format code per pin |
| load_mode | input | NUM_PINS x 2 | Load control mode per pin |
| drv_data | output | NUM_PINS | Formatted drive level |
| drv_en | output | NUM_PINS | Formatted driver enable |
| load_en | output | NUM_PINS | Active load switch |

## Verification
The synchronous clear and a rising timing edge on a held-level path can fall in the same cycle. The bench provokes this by raising the timing input of both paths in the very sample where the clear is high, with the pattern bit at 1. It judges the result by requiring both outputs to be 0 one clock later and to stay 0 until a later rising edge without clear. In that same cycle a return-to-zero path on another pin must still follow its pattern and timing. A second coincidence is a drive-enable change under load mode 0: the load must flip on exactly the edge where the enable flips.

// File: rtl/pwf_pkg.sv
package pwf_pkg;
  localparam int SEL_W  = 3;
  localparam int LOAD_W = 2;

  localparam logic [SEL_W-1:0] FMT_HOLD = 3'd0;
  localparam logic [SEL_W-1:0] FMT_RZ   = 3'd1;
  localparam logic [SEL_W-1:0] FMT_RTO  = 3'd2;
  localparam logic [SEL_W-1:0] FMT_XOR  = 3'd3;
  localparam logic [SEL_W-1:0] FMT_ONE  = 3'd4;
  localparam logic [SEL_W-1:0] FMT_ZERO = 3'd5;

  localparam logic [LOAD_W-1:0] LD_FOLLOW = 2'd0;
  localparam logic [LOAD_W-1:0] LD_ON     = 2'd1;

  localparam int NUM_PATHS = 2;
  localparam int PATH_DAT  = 0;
  localparam int PATH_ENA  = 1;
endpackage

// File: rtl/pwf_hold_stage.sv
module pwf_hold_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pat,
  input  logic tg,
  output logic held_now
);
  logic tg_q;
  logic hold_q;
  logic tg_rise;

  assign tg_rise  = tg & ~tg_q;
  assign held_now = clr ? 1'b0 : (tg_rise ? pat : hold_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tg_q   <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      tg_q   <= tg;
      hold_q <= held_now;
    end
  end

  p_hold_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(tg && !tg_q)) |=> $stable(hold_q));
  p_hold_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && tg && !tg_q) |=> (hold_q == $past(pat)));
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hold_q == 1'b0));
endmodule

// File: rtl/pwf_fmt_mux.sv
module pwf_fmt_mux
  import pwf_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             held,
  input  logic             pat,
  input  logic             tg,
  output logic             y
);
  always_comb begin
    case (sel)
      FMT_HOLD: y = held;
      FMT_RZ:   y = pat & tg;
      FMT_RTO:  y = pat | ~tg;
      FMT_XOR:  y = pat ^ tg;
      FMT_ONE:  y = 1'b1;
      FMT_ZERO: y = 1'b0;
      default:  y = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwf_pin_slice.sv
module pwf_pin_slice
  import pwf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              dat_pat,
  input  logic              dat_tg,
  input  logic [SEL_W-1:0]  dat_sel,
  input  logic              ena_pat,
  input  logic              ena_tg,
  input  logic [SEL_W-1:0]  ena_sel,
  input  logic [LOAD_W-1:0] load_mode,
  output logic              drv_data,
  output logic              drv_en,
  output logic              load_en
);
  logic [NUM_PATHS-1:0]            p_pat, p_tg, p_held, p_y;
  logic [NUM_PATHS-1:0][SEL_W-1:0] p_sel;
  logic                            load_next;
  logic                            armed_q;

  assign p_pat[PATH_DAT] = dat_pat;
  assign p_tg [PATH_DAT] = dat_tg;
  assign p_sel[PATH_DAT] = dat_sel;
  assign p_pat[PATH_ENA] = ena_pat;
  assign p_tg [PATH_ENA] = ena_tg;
  assign p_sel[PATH_ENA] = ena_sel;

  for (genvar k = 0; k < NUM_PATHS; k++) begin : g_path
    pwf_hold_stage u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .pat      (p_pat[k]),
      .tg       (p_tg[k]),
      .held_now (p_held[k])
    );
    pwf_fmt_mux u_mux (
      .sel  (p_sel[k]),
      .held (p_held[k]),
      .pat  (p_pat[k]),
      .tg   (p_tg[k]),
      .y    (p_y[k])
    );
  end

  always_comb begin
    case (load_mode)
      LD_FOLLOW: load_next = ~p_y[PATH_ENA];
      LD_ON:     load_next = 1'b1;
      default:   load_next = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_data <= 1'b0;
      drv_en   <= 1'b0;
      load_en  <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      drv_data <= p_y[PATH_DAT];
      drv_en   <= p_y[PATH_ENA];
      load_en  <= load_next;
      armed_q  <= 1'b1;
    end
  end

  p_rz_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(dat_sel == FMT_RZ && !dat_pat) |-> !drv_data);
  p_rto_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(dat_sel == FMT_RTO && !dat_tg) |-> drv_data);
  p_xor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(dat_sel == FMT_XOR) |-> (drv_data == ($past(dat_pat) ^ $past(dat_tg))));
  p_static_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(ena_sel == FMT_ONE) |-> drv_en);
  p_static_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(ena_sel >= FMT_ZERO) |-> !drv_en);
  p_load_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(load_mode == LD_FOLLOW) |-> (load_en != drv_en));
  p_load_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(load_mode == LD_ON) |-> load_en);
endmodule

// File: rtl/pwf_format_combiner.sv
module pwf_format_combiner
  import pwf_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clr,
  input  logic [NUM_PINS-1:0]              dat_pat,
  input  logic [NUM_PINS-1:0]              dat_tg,
  input  logic [NUM_PINS-1:0][SEL_W-1:0]   dat_sel,
  input  logic [NUM_PINS-1:0]              ena_pat,
  input  logic [NUM_PINS-1:0]              ena_tg,
  input  logic [NUM_PINS-1:0][SEL_W-1:0]   ena_sel,
  input  logic [NUM_PINS-1:0][LOAD_W-1:0]  load_mode,
  output logic [NUM_PINS-1:0]              drv_data,
  output logic [NUM_PINS-1:0]              drv_en,
  output logic [NUM_PINS-1:0]              load_en
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pwf_pin_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .dat_pat   (dat_pat[p]),
      .dat_tg    (dat_tg[p]),
      .dat_sel   (dat_sel[p]),
      .ena_pat   (ena_pat[p]),
      .ena_tg    (ena_tg[p]),
      .ena_sel   (ena_sel[p]),
      .load_mode (load_mode[p]),
      .drv_data  (drv_data[p]),
      .drv_en    (drv_en[p]),
      .load_en   (load_en[p])
    );
  end
endmodule

// File: tb/tb_pwf_format_combiner.sv
module tb_pwf_format_combiner;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic [NP-1:0]      dat_pat = '0, dat_tg = '0, ena_pat = '0, ena_tg = '0;
  logic [NP-1:0][2:0] dat_sel = '0, ena_sel = '0;
  logic [NP-1:0][1:0] load_mode = '0;
  logic [NP-1:0]      drv_data, drv_en, load_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // requirement model state
  logic [NP-1:0] m_dtq = '0, m_dh = '0, m_etq = '0, m_eh = '0;
  logic [NP-1:0] e_data = '0, e_en = '0, e_load = '0;

  always #2 clk = ~clk;

  pwf_format_combiner #(.NUM_PINS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .dat_pat(dat_pat), .dat_tg(dat_tg), .dat_sel(dat_sel),
    .ena_pat(ena_pat), .ena_tg(ena_tg), .ena_sel(ena_sel),
    .load_mode(load_mode),
    .drv_data(drv_data), .drv_en(drv_en), .load_en(load_en)
  );

  function automatic logic fmt(input logic [2:0] s, input logic h,
                               input logic p, input logic t);
    case (s)
      3'd0: return h;
      3'd1: return p & t;
      3'd2: return p | ~t;
      3'd3: return p ^ t;
      3'd4: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [NP-1:0] act,
                       input logic [NP-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock: model the sampled inputs, then compare after the edge
  task automatic cyc(input string tag);
    @(posedge clk);
    for (int p = 0; p < NP; p++) begin
      logic hd, he;
      hd = clr ? 1'b0 : ((dat_tg[p] && !m_dtq[p]) ? dat_pat[p] : m_dh[p]);
      he = clr ? 1'b0 : ((ena_tg[p] && !m_etq[p]) ? ena_pat[p] : m_eh[p]);
      m_dh[p] = hd; m_eh[p] = he;
      m_dtq[p] = dat_tg[p]; m_etq[p] = ena_tg[p];
      e_data[p] = fmt(dat_sel[p], hd, dat_pat[p], dat_tg[p]);
      e_en[p]   = fmt(ena_sel[p], he, ena_pat[p], ena_tg[p]);
      e_load[p] = (load_mode[p] == 2'd0) ? ~e_en[p] : (load_mode[p] == 2'd1);
    end
    #1;
    check(tag, drv_data, e_data, "drv_data");
    check(tag, drv_en, e_en, "drv_en");
    check(tag, load_en, e_load, "load_en");
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_dtq = '0; m_dh = '0; m_etq = '0; m_eh = '0;
    #1;
    check("R9", drv_data, '0, "drv_data in reset");
    check("R9", drv_en, '0, "drv_en in reset");
    check("R9", load_en, '0, "load_en in reset");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_edge();
    do_reset();
    dat_sel = '0; ena_sel = '0;
    dat_pat = '1; dat_tg = '1; ena_pat = '1; ena_tg = '1;
    cyc("R9");
    check("R9", drv_data, '1, "first-sample rise captured");
    dat_pat = '0;
    cyc("R1");
    dat_tg = '0; ena_tg = '0;
    cyc("R1");
  endtask

  task automatic t_hold();
    dat_sel = '0;
    for (int i = 0; i < 12; i++) begin
      dat_pat = (i % 3 == 0) ? '1 : '0;
      dat_tg  = (i % 4 < 2) ? '1 : '0;
      cyc("R1");
    end
    dat_pat = '1; dat_tg = '1;
    cyc("R1");
    dat_pat = '0;
    cyc("R1");
    check("R1", drv_data, '1, "held across pattern change");
  endtask

  task automatic t_combine(input logic [2:0] code, input string tag);
    for (int p = 0; p < NP; p++) dat_sel[p] = code;
    for (int i = 0; i < 4; i++) begin
      dat_pat = {NP{i[0]}};
      dat_tg  = {NP{i[1]}};
      cyc(tag);
    end
  endtask

  task automatic t_static();
    for (int c = 4; c < 8; c++) begin
      for (int p = 0; p < NP; p++) begin dat_sel[p] = 3'(c); ena_sel[p] = 3'(c); end
      for (int i = 0; i < 4; i++) begin
        dat_pat = {NP{i[0]}}; dat_tg = {NP{i[1]}};
        ena_pat = {NP{i[1]}}; ena_tg = {NP{i[0]}};
        cyc("R5");
        check("R5", drv_data, (c == 4) ? '1 : '0, "static code");
      end
    end
  endtask

  task automatic t_enable();
    for (int p = 0; p < NP; p++) begin dat_sel[p] = 3'd1; ena_sel[p] = 3'd2; load_mode[p] = 2'd0; end
    for (int i = 0; i < 8; i++) begin
      dat_pat = {NP{i[0]}}; dat_tg = {NP{i[1]}};
      ena_pat = {NP{i[2]}}; ena_tg = {NP{i[0]}};
      cyc("R6");
    end
    for (int p = 0; p < NP; p++) ena_sel[p] = 3'd3;
    for (int i = 0; i < 4; i++) begin
      ena_pat = {NP{i[0]}}; ena_tg = {NP{i[1]}};
      cyc("R6");
    end
  endtask

  task automatic t_load();
    for (int p = 0; p < NP; p++) ena_sel[p] = 3'd1;
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < NP; p++) load_mode[p] = 2'(m);
      for (int i = 0; i < 4; i++) begin
        ena_pat = {NP{i[0]}}; ena_tg = {NP{i[1]}};
        cyc("R7");
        if (m == 0) check("R7", load_en, ~drv_en, "load opposite of enable");
      end
    end
    for (int p = 0; p < NP; p++) load_mode[p] = 2'd0;
  endtask

  task automatic t_clear();
    dat_sel = '0; ena_sel = '0;
    dat_sel[3] = 3'd1;
    dat_pat = '1; ena_pat = '1; dat_tg = '0; ena_tg = '0;
    cyc("R8");
    dat_tg = '1; ena_tg = '1; clr = 1'b1;
    cyc("R8");
    check("R8", drv_data & 4'b0111, '0, "clear over rise (data)");
    check("R8", drv_en, '0, "clear over rise (enable)");
    check("R8", drv_data & 4'b1000, 4'b1000, "other format unaffected");
    clr = 1'b0;
    cyc("R8");
    check("R8", drv_en, '0, "stays cleared without new rise");
    dat_tg = '0; ena_tg = '0;
    cyc("R8");
    dat_tg = '1; ena_tg = '1;
    cyc("R8");
    check("R8", drv_en, '1, "new rise after clear");
    clr = 1'b1; dat_tg = '0; ena_tg = '0;
    cyc("R8");
    clr = 1'b0;
    cyc("R8");
  endtask

  task automatic t_pins();
    dat_sel[0] = 3'd0; dat_sel[1] = 3'd1; dat_sel[2] = 3'd2; dat_sel[3] = 3'd3;
    ena_sel[0] = 3'd4; ena_sel[1] = 3'd3; ena_sel[2] = 3'd0; ena_sel[3] = 3'd5;
    load_mode[0] = 2'd0; load_mode[1] = 2'd1; load_mode[2] = 2'd2; load_mode[3] = 2'd3;
    for (int i = 0; i < 16; i++) begin
      dat_pat = 4'(i); dat_tg = 4'(i * 5); ena_pat = 4'(~i); ena_tg = 4'(i * 3);
      cyc("R10");
    end
  endtask

  initial begin
    do_reset();
    t_reset_edge();
    t_hold();
    t_combine(3'd1, "R2");
    t_combine(3'd2, "R3");
    t_combine(3'd3, "R4");
    t_static();
    t_enable();
    t_load();
    t_clear();
    t_pins();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired before all requirement checks finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule